// File: doc/BRIEF.md
# Staged Pipeline Control Decoder

This block turns the opcode of the instruction held in the decode stage of a five-stage in-order pipeline into nine control lines. It then moves those lines down the pipeline alongside the instruction. Control is produced once, in decode. It is split into three groups, one for execute, one for memory access and one for write-back. Each group rides the pipeline registers only as far as the stage that consumes it and is dropped after that. The decode-to-execute register therefore holds all three groups. The execute-to-memory register holds the memory and write-back groups. The memory-to-write-back register holds only the write-back group.

A bubble request replaces the decoded control with all zeros as it enters the execute stage. The inserted slot then neither writes memory nor writes the register file. Opcodes the decoder does not recognise also produce all-zero control and behave as a no-op. The datapath, register file, ALU, memories and the ALU function decode beyond the 2-bit operation class are outside the block.

All pins are plain control: every stage advances on every clock. There is no valid/ready handshake, and the block never stalls its neighbours.

Top module: `pctl_stager`

## Requirements
- R1: A synchronous reset clears every staged control output to 0 at the first clock edge where reset is high.
- R2: Opcode 0x00 (register-register class) gives, one cycle later, ex_reg_dst=1, ex_alu_op=2'b10 and ex_alu_src=0. Its memory controls are 0, and its write-back controls are wb_reg_write=1 and wb_mem_to_reg=0.
- R3: Opcode 0x23 (load) gives ex_reg_dst=0, ex_alu_op=2'b00 and ex_alu_src=1. Its memory controls are mem_read=1, mem_write=0 and mem_branch=0, and it writes back with wb_reg_write=1 and wb_mem_to_reg=1.
- R4: Opcode 0x2B (store) gives ex_alu_op=2'b00, ex_alu_src=1, mem_write=1, mem_read=0, mem_branch=0 and wb_reg_write=0. The don't-care lines ex_reg_dst and wb_mem_to_reg are driven 0.
- R5: Opcode 0x04 (branch on equal) gives ex_alu_op=2'b01, ex_alu_src=0, mem_branch=1, mem_read=0, mem_write=0 and wb_reg_write=0. The don't-care lines ex_reg_dst and wb_mem_to_reg are driven 0.
- R6: Every other 6-bit opcode produces all-zero control in every stage it reaches.
- R7: When id_bubble is high at a clock edge, the execute-stage outputs become 0 one cycle later, whatever the opcode. The same slot gives mem outputs of 0 one cycle after that and wb outputs of 0 one cycle after that.
- R8: The execute group appears one cycle after decode, the memory group two cycles after and the write-back group three cycles after. Back-to-back instructions keep their groups in lockstep, with no slot lost or repeated.
- R9: mem_read and mem_write are never both high, and wb_mem_to_reg is never high without wb_reg_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_opcode | input | 6 | Opcode of the instruction now in decode |
| id_bubble | input | 1 | Insert an all-zero control slot instead of the decoded one |
| ex_reg_dst | output | 1 | Execute stage: destination register taken from the third register field |
| ex_alu_op | output | 2 | Execute stage: ALU operation class (00 add, 01 subtract/compare, 10 function field) |
| ex_alu_src | output | 1 | Execute stage: second ALU operand is the immediate |
| mem_branch | output | 1 | Memory stage: instruction is a conditional branch |
| mem_read | output | 1 | Memory stage: data memory read |
| mem_write | output | 1 | Memory stage: data memory write |
| wb_reg_write | output | 1 | Write-back stage: register file write enable |
| wb_mem_to_reg | output | 1 | Write-back stage: write data comes from memory |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the four recognised codes 0x00, 0x23, 0x2B and 0x04. With a 6-bit opcode the whole code space is small enough to sweep, so every one of the 64 values passes through all three stages. That shows every unrecognised code decodes to a no-op, alongside the four that are recognised. Mixed streams with bubbles placed between and on top of instructions show that each group lines up with its own instruction three stages deep.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

  typedef struct packed {
    logic       dst_rd;
    logic [1:0] alu_mode;
    logic       alu_imm;
  } exec_grp_t;

  typedef struct packed {
    logic br;
    logic rd;
    logic wr;
  } mem_grp_t;

  typedef struct packed {
    logic rf_we;
    logic from_mem;
  } wb_grp_t;

  typedef struct packed {
    exec_grp_t ex;
    mem_grp_t  mm;
    wb_grp_t   wb;
  } ctl_all_t;

  typedef struct packed {
    mem_grp_t mm;
    wb_grp_t  wb;
  } ctl_late_t;

  localparam int ALL_W  = $bits(ctl_all_t);
  localparam int LATE_W = $bits(ctl_late_t);
  localparam int WB_W   = $bits(wb_grp_t);

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_CMP  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
  import pctl_pkg::*;
#(
  parameter int             OPW   = 6,
  parameter logic [OPW-1:0] OP_RR = 6'h00,
  parameter logic [OPW-1:0] OP_LD = 6'h23,
  parameter logic [OPW-1:0] OP_ST = 6'h2B,
  parameter logic [OPW-1:0] OP_BE = 6'h04
) (
  input  logic [OPW-1:0] opcode,
  output ctl_all_t       ctl
);

  always_comb begin
    ctl = '0;
    if (opcode == OP_RR) begin
      ctl.ex.dst_rd   = 1'b1;
      ctl.ex.alu_mode = ALU_FUNC;
      ctl.wb.rf_we    = 1'b1;
    end else if (opcode == OP_LD) begin
      ctl.ex.alu_mode = ALU_ADD;
      ctl.ex.alu_imm  = 1'b1;
      ctl.mm.rd       = 1'b1;
      ctl.wb.rf_we    = 1'b1;
      ctl.wb.from_mem = 1'b1;
    end else if (opcode == OP_ST) begin
      ctl.ex.alu_mode = ALU_ADD;
      ctl.ex.alu_imm  = 1'b1;
      ctl.mm.wr       = 1'b1;
    end else if (opcode == OP_BE) begin
      ctl.ex.alu_mode = ALU_CMP;
      ctl.mm.br       = 1'b1;
    end
  end

endmodule

// File: rtl/pctl_stage.sv
module pctl_stage #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= d;
  end

endmodule

// File: rtl/pctl_stager.sv
module pctl_stager
  import pctl_pkg::*;
#(
  parameter int             OPW   = 6,
  parameter logic [OPW-1:0] OP_RR = 6'h00,
  parameter logic [OPW-1:0] OP_LD = 6'h23,
  parameter logic [OPW-1:0] OP_ST = 6'h2B,
  parameter logic [OPW-1:0] OP_BE = 6'h04
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] id_opcode,
  input  logic           id_bubble,
  output logic           ex_reg_dst,
  output logic [1:0]     ex_alu_op,
  output logic           ex_alu_src,
  output logic           mem_branch,
  output logic           mem_read,
  output logic           mem_write,
  output logic           wb_reg_write,
  output logic           wb_mem_to_reg
);

  ctl_all_t  dec_ctl;
  ctl_all_t  idex_q;
  ctl_late_t exmem_d, exmem_q;
  wb_grp_t   memwb_q;

  pctl_decode #(
    .OPW(OPW), .OP_RR(OP_RR), .OP_LD(OP_LD), .OP_ST(OP_ST), .OP_BE(OP_BE)
  ) u_dec (
    .opcode(id_opcode),
    .ctl   (dec_ctl)
  );

  // Decode -> execute: all three groups; bubble zeroes the slot.
  pctl_stage #(.W(ALL_W)) u_idex (
    .clk(clk), .rst(rst), .clr(id_bubble),
    .d(dec_ctl), .q(idex_q)
  );

  // Execute group is consumed here; memory and write-back continue.
  assign exmem_d.mm = idex_q.mm;
  assign exmem_d.wb = idex_q.wb;

  pctl_stage #(.W(LATE_W)) u_exmem (
    .clk(clk), .rst(rst), .clr(1'b0),
    .d(exmem_d), .q(exmem_q)
  );

  // Memory group is consumed here; only write-back continues.
  pctl_stage #(.W(WB_W)) u_memwb (
    .clk(clk), .rst(rst), .clr(1'b0),
    .d(exmem_q.wb), .q(memwb_q)
  );

  assign ex_reg_dst    = idex_q.ex.dst_rd;
  assign ex_alu_op     = idex_q.ex.alu_mode;
  assign ex_alu_src    = idex_q.ex.alu_imm;
  assign mem_branch    = exmem_q.mm.br;
  assign mem_read      = exmem_q.mm.rd;
  assign mem_write     = exmem_q.mm.wr;
  assign wb_reg_write  = memwb_q.rf_we;
  assign wb_mem_to_reg = memwb_q.from_mem;

  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write));

  assert_memsel_needs_we_R9: assert property (@(posedge clk) disable iff (rst)
    wb_mem_to_reg |-> wb_reg_write);

  assert_bubble_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $past(id_bubble) |-> (idex_q == '0));

  assert_lockstep_wb_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (memwb_q == $past(exmem_q.wb)));

  assert_branch_no_we_R5: assert property (@(posedge clk) disable iff (rst)
    exmem_q.mm.br |-> !exmem_q.wb.rf_we);

  assert_dst_func_R2: assert property (@(posedge clk) disable iff (rst)
    ex_reg_dst |-> (ex_alu_op == ALU_FUNC));

endmodule

// File: tb/test_pctl_stager.sv
module test_pctl_stager;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] id_opcode = '0;
  logic       id_bubble = 1'b0;
  logic       ex_reg_dst, ex_alu_src, mem_branch, mem_read, mem_write;
  logic       wb_reg_write, wb_mem_to_reg;
  logic [1:0] ex_alu_op;

  int n_chk = 0;
  int n_bad = 0;

  // model slots: {dst, alu[1:0], imm, br, rd, wr, we, m2r}
  logic [8:0] m_idex  = '0;
  logic [4:0] m_exmem = '0;
  logic [1:0] m_memwb = '0;

  always #10 clk = ~clk;

  pctl_stager i_pctl_stager (
    .clk(clk), .rst(rst), .id_opcode(id_opcode), .id_bubble(id_bubble),
    .ex_reg_dst(ex_reg_dst), .ex_alu_op(ex_alu_op), .ex_alu_src(ex_alu_src),
    .mem_branch(mem_branch), .mem_read(mem_read), .mem_write(mem_write),
    .wb_reg_write(wb_reg_write), .wb_mem_to_reg(wb_mem_to_reg)
  );

  function automatic logic [8:0] ref_ctl(input logic [5:0] op);
    case (op)
      6'h00:   return 9'b1_10_0_000_10;
      6'h23:   return 9'b0_00_1_010_11;
      6'h2B:   return 9'b0_00_1_001_00;
      6'h04:   return 9'b0_01_0_100_00;
      default: return 9'b0;
    endcase
  endfunction

  // One clock: drive after negedge, update model, compare after posedge.
  task automatic step(input logic [5:0] op, input logic bub, input logic r,
                      input string tag);
    logic [8:0] act, exp;
    @(negedge clk);
    id_opcode = op;
    id_bubble = bub;
    rst       = r;
    @(posedge clk);
    if (r) begin
      m_idex = '0; m_exmem = '0; m_memwb = '0;
    end else begin
      m_memwb = m_exmem[1:0];
      m_exmem = m_idex[4:0];
      m_idex  = bub ? 9'b0 : ref_ctl(op);
    end
    #2;
    act = {ex_reg_dst, ex_alu_op, ex_alu_src, mem_branch, mem_read, mem_write,
           wb_reg_write, wb_mem_to_reg};
    exp = {m_idex[8:5], m_exmem[4:2], m_memwb};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h bub=%0b actual=%b expected=%b", tag, op, bub, act, exp);
    end
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3; i++) step(6'h3F, 1'b0, 1'b0, tag);
  endtask

  task automatic t_reset;
    step(6'h23, 1'b0, 1'b0, "R3 prime");
    step(6'h00, 1'b0, 1'b0, "R2 prime");
    step(6'h23, 1'b0, 1'b1, "R1 reset clears");
    step(6'h00, 1'b0, 1'b1, "R1 reset held");
  endtask

  task automatic t_single(input logic [5:0] op, input string tag);
    step(op, 1'b0, 1'b0, tag);
    drain(tag);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 64; k++) step(6'(k), 1'b0, 1'b0, "R6 sweep");
    drain("R6 sweep drain");
  endtask

  task automatic t_bubble;
    step(6'h23, 1'b1, 1'b0, "R7 bubble on load");
    step(6'h00, 1'b0, 1'b0, "R7 after bubble");
    step(6'h2B, 1'b1, 1'b0, "R7 bubble on store");
    step(6'h04, 1'b1, 1'b0, "R7 bubble on branch");
    drain("R7 drain");
  endtask

  task automatic t_stream;
    logic [5:0] seq [8] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h23, 6'h23, 6'h11, 6'h00};
    for (int k = 0; k < 8; k++) step(seq[k], 1'b0, 1'b0, "R8 stream");
    for (int k = 0; k < 8; k++) step(seq[k], (k % 3) == 1, 1'b0, "R8 stream+bubble");
    drain("R8 drain");
  endtask

  initial begin
    #250000;
    n_bad++;
    $display("FAIL watchdog R8 actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(6'h00, 1'b0, 1'b1, "R1 initial reset");
    step(6'h00, 1'b0, 1'b1, "R1 initial reset");
    t_reset();
    t_single(6'h00, "R2 register-register");
    t_single(6'h23, "R3 load");
    t_single(6'h2B, "R4 store");
    t_single(6'h04, "R5 branch");
    t_single(6'h05, "R6 unknown");
    t_sweep();
    t_bubble();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule